// File: doc/BRIEF.md
# PCI Configuration Cycle Translator

This block sits between the processor's I/O port space and the PCI configuration fabric. It owns the configuration address register. That register selects a bus, a device, a function and a dword register. The block treats the configuration data port as a window onto the register that the address selects. An I/O access to the data port turns into a configuration read or write while the enable bit of the address register is set. Every other I/O cycle passes downstream as a plain I/O cycle.

Each request is routed to one of four targets. Two are internal bus-0 functions: the host bridge and the virtual PCI-to-PCI bridge. The other two are external links: the downstream hub link and the graphics Express port. The graphics port receives every bus number inside the range that the virtual bridge decodes. The secondary and subordinate bus numbers arrive as inputs from that bridge's register file. The processor side is a single-outstanding request/response port. Toward the targets there is one shared request bus with a one-hot valid and a completion input per target.

Top module: `cfg_cycle_xlator`

## Requirements
- R1: A write with all four byte enables to dword address 0x33E (I/O 0CF8h) loads the address register. Bits 30:24 and 1:0 are forced to zero. A read of dword 0x33E returns the register. Both get a response with read data 0 for the write, and neither reaches a target.
- R2: A write to dword 0x33E with any byte enable clear leaves the address register unchanged. It is forwarded to the hub (target index 2) as an I/O write.
- R3: An access to dword 0x33F (I/O 0CFCh) while address bit 31 is 1 becomes a configuration request. Its write flag follows the I/O direction. Its byte enables and write data are passed unchanged. Its address is the register value with bits 31:24 and 1:0 cleared, so the bus is in 23:16, the device in 15:11, the function in 10:8 and the dword index in 7:2.
- R4: While address bit 31 is 0, an access to dword 0x33F goes to the hub as an I/O cycle with address {dword,2'b00}. So does any access to a dword other than 0x33E or 0x33F.
- R5: A configuration access to bus 0 goes to the host bridge (index 0) for device 0 and to the virtual bridge (index 1) for device 1, as type 0 (type1 flag low).
- R6: A configuration access to bus 0 with a device number other than 0 or 1 goes to the hub as type 0.
- R7: A configuration access whose bus satisfies secondary <= bus <= subordinate goes to the graphics port (index 3). It is type 0 when the bus equals the secondary number and type 1 otherwise.
- R8: A configuration access to any other non-zero bus goes to the hub as type 1.
- R9: A configuration access to a non-zero function of device 0 or 1 on bus 0 is not forwarded. A read returns 0xFFFFFFFF, and a write is discarded and returns 0.
- R10: A read completion flagged absent returns 0xFFFFFFFF to the processor instead of the completion data.
- R11: A forwarded request is a one-cycle pulse in the cycle after acceptance, and ready is low until the response. The response is a one-cycle pulse in the cycle after the completion is sampled, or in the cycle after acceptance for a locally answered access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | Processor I/O request valid |
| io_req_ready | output | 1 | Block idle, request accepted when valid |
| io_req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_req_dwaddr | input | 14 | I/O dword address (byte address bits 15:2) |
| io_req_be | input | 4 | Byte enables |
| io_req_wdata | input | 32 | Write data |
| io_rsp_valid | output | 1 | Response pulse |
| io_rsp_rdata | output | 32 | Read data (0 for writes) |
| sec_bus | input | 8 | Secondary bus number of the virtual bridge |
| sub_bus | input | 8 | Subordinate bus number of the virtual bridge |
| tgt_req_valid | output | 4 | One-hot request pulse: 0 host, 1 bridge, 2 hub, 3 graphics |
| tgt_req_write | output | 1 | Request is a write |
| tgt_req_cfg | output | 1 | 1 = configuration cycle, 0 = I/O cycle |
| tgt_req_type1 | output | 1 | Configuration type 1 flag |
| tgt_req_addr | output | 32 | Configuration or I/O byte address |
| tgt_req_be | output | 4 | Byte enables |
| tgt_req_wdata | output | 32 | Write data |
| tgt_cpl_valid | input | 4 | Completion valid, one bit per target |
| tgt_cpl_absent | input | 4 | Completion reports no function present |
| tgt_cpl_data | input | 128 | Completion data, 32 bits per target, target 0 lowest |

## Verification
The request for a forwarded access is due on the edge after acceptance. The bench samples it at the following falling edge and answers on that same falling edge. The response then appears one edge later, and the bench checks it at the next falling edge. A locally answered access produces its response at the first falling edge after acceptance, with no target pulse. One more falling edge later, the bench confirms that both pulses have ended and ready is high again. Because every sample lands on a falling edge, a result that is early or late by a single cycle is caught.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int IO_DW_W = 14;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int NUM_TGT = 4;
    localparam int TGT_W   = $clog2(NUM_TGT);

    localparam logic [IO_DW_W-1:0] ADDR_PORT_DW = 14'h33E;
    localparam logic [IO_DW_W-1:0] DATA_PORT_DW = 14'h33F;
    localparam logic [DATA_W-1:0]  ADDR_KEEP    = 32'h80FF_FFFC;
    localparam logic [DATA_W-1:0]  CFG_ADDR_MSK = 32'h00FF_FFFC;
    localparam logic [DATA_W-1:0]  ALL_ONES     = '1;

    typedef enum logic [TGT_W-1:0] {
        TGT_HOST   = 2'd0,
        TGT_BRIDGE = 2'd1,
        TGT_HUB    = 2'd2,
        TGT_GFX    = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } st_e;

    typedef struct packed {
        st_e                 st;
        tgt_e                tgt;
        logic [NUM_TGT-1:0]  req_vld;
        logic                wr;
        logic                cfg;
        logic                type1;
        logic [DATA_W-1:0]   addr;
        logic [BE_W-1:0]     be;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } ctl_s;
endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) val_d = wdata & ADDR_KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;

    // R1: the register changes only through a qualified load
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(val_q));

    // R1: reserved bits never hold a one
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q & ~ADDR_KEEP) == '0);
endmodule

// File: rtl/cfgx_router.sv
module cfgx_router
    import cfgx_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output tgt_e             tgt,
    output logic             type1,
    output logic             absent
);
    always_comb begin
        tgt    = TGT_HUB;
        type1  = 1'b1;
        absent = 1'b0;
        if (bus == '0) begin
            type1 = 1'b0;
            if (dev == DEV_W'(0)) begin
                tgt    = TGT_HOST;
                absent = (fn != '0);
            end else if (dev == DEV_W'(1)) begin
                tgt    = TGT_BRIDGE;
                absent = (fn != '0);
            end
        end else if (bus >= sec_bus && bus <= sub_bus) begin
            tgt   = TGT_GFX;
            type1 = (bus != sec_bus);
        end
    end
endmodule

// File: rtl/cfg_cycle_xlator.sv
module cfg_cycle_xlator
    import cfgx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_req_valid,
    output logic                      io_req_ready,
    input  logic                      io_req_write,
    input  logic [IO_DW_W-1:0]        io_req_dwaddr,
    input  logic [BE_W-1:0]           io_req_be,
    input  logic [DATA_W-1:0]         io_req_wdata,
    output logic                      io_rsp_valid,
    output logic [DATA_W-1:0]         io_rsp_rdata,
    input  logic [BUS_W-1:0]          sec_bus,
    input  logic [BUS_W-1:0]          sub_bus,
    output logic [NUM_TGT-1:0]        tgt_req_valid,
    output logic                      tgt_req_write,
    output logic                      tgt_req_cfg,
    output logic                      tgt_req_type1,
    output logic [DATA_W-1:0]         tgt_req_addr,
    output logic [BE_W-1:0]           tgt_req_be,
    output logic [DATA_W-1:0]         tgt_req_wdata,
    input  logic [NUM_TGT-1:0]        tgt_cpl_valid,
    input  logic [NUM_TGT-1:0]        tgt_cpl_absent,
    input  logic [NUM_TGT*DATA_W-1:0] tgt_cpl_data
);
    ctl_s ctl_d, ctl_q;

    logic [DATA_W-1:0] car_q;
    logic              car_load;
    tgt_e              rt_tgt;
    logic              rt_type1;
    logic              rt_absent;
    logic [DATA_W-1:0] cpl_word [NUM_TGT];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TGT; gi++) begin : g_cpl
            assign cpl_word[gi] = tgt_cpl_data[gi*DATA_W +: DATA_W];
        end
    endgenerate

    cfgx_addr_reg u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (car_load),
        .wdata (io_req_wdata),
        .value (car_q)
    );

    cfgx_router u_route (
        .bus     (car_q[23:16]),
        .dev     (car_q[15:11]),
        .fn      (car_q[10:8]),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .tgt     (rt_tgt),
        .type1   (rt_type1),
        .absent  (rt_absent)
    );

    logic accept, hit_addr, hit_data, full_be;
    assign accept   = io_req_valid && (ctl_q.st == ST_IDLE);
    assign hit_addr = (io_req_dwaddr == ADDR_PORT_DW);
    assign hit_data = (io_req_dwaddr == DATA_PORT_DW);
    assign full_be  = &io_req_be;
    assign car_load = accept && io_req_write && hit_addr && full_be;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.req_vld = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (io_req_valid) begin
                    ctl_d.wr    = io_req_write;
                    ctl_d.be    = io_req_be;
                    ctl_d.wdata = io_req_wdata;
                    ctl_d.rdata = '0;
                    if (hit_addr && (full_be || !io_req_write)) begin
                        ctl_d.st = ST_RESP;
                        if (!io_req_write) ctl_d.rdata = car_q;
                    end else if (hit_data && car_q[31] && rt_absent) begin
                        ctl_d.st = ST_RESP;
                        if (!io_req_write) ctl_d.rdata = ALL_ONES;
                    end else if (hit_data && car_q[31]) begin
                        ctl_d.st      = ST_WAIT;
                        ctl_d.tgt     = rt_tgt;
                        ctl_d.cfg     = 1'b1;
                        ctl_d.type1   = rt_type1;
                        ctl_d.addr    = car_q & CFG_ADDR_MSK;
                        ctl_d.req_vld = NUM_TGT'(1) << rt_tgt;
                    end else begin
                        ctl_d.st      = ST_WAIT;
                        ctl_d.tgt     = TGT_HUB;
                        ctl_d.cfg     = 1'b0;
                        ctl_d.type1   = 1'b0;
                        ctl_d.addr    = {{(DATA_W-IO_DW_W-2){1'b0}}, io_req_dwaddr, 2'b00};
                        ctl_d.req_vld = NUM_TGT'(1) << TGT_HUB;
                    end
                end
            end
            ST_WAIT: begin
                if (tgt_cpl_valid[ctl_q.tgt]) begin
                    ctl_d.st = ST_RESP;
                    if (ctl_q.wr)                         ctl_d.rdata = '0;
                    else if (tgt_cpl_absent[ctl_q.tgt])   ctl_d.rdata = ALL_ONES;
                    else                                  ctl_d.rdata = cpl_word[ctl_q.tgt];
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= ST_IDLE;
            ctl_q.tgt     <= TGT_HOST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign io_req_ready  = (ctl_q.st == ST_IDLE);
    assign io_rsp_valid  = (ctl_q.st == ST_RESP);
    assign io_rsp_rdata  = ctl_q.rdata;
    assign tgt_req_valid = ctl_q.req_vld;
    assign tgt_req_write = ctl_q.wr;
    assign tgt_req_cfg   = ctl_q.cfg;
    assign tgt_req_type1 = ctl_q.type1;
    assign tgt_req_addr  = ctl_q.addr;
    assign tgt_req_be    = ctl_q.be;
    assign tgt_req_wdata = ctl_q.wdata;

    // R11: at most one target addressed, for a single cycle
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_req_valid));
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid != '0) |=> (tgt_req_valid == '0));
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_rsp_valid |=> !io_rsp_valid);
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid != '0) |-> !io_req_ready);
    // R7: graphics requests stay inside the bridge's bus window
    a_r7_gfx_range: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid[TGT_GFX] |-> (tgt_req_cfg &&
            tgt_req_addr[23:16] >= sec_bus && tgt_req_addr[23:16] <= sub_bus));
    a_r7_gfx_type: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid[TGT_GFX] |-> (tgt_req_type1 == (tgt_req_addr[23:16] != sec_bus)));
    // R5: internal functions see only bus 0 type 0 cycles
    a_r5_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid[TGT_HOST] || tgt_req_valid[TGT_BRIDGE]) |->
            (tgt_req_cfg && !tgt_req_type1 && tgt_req_addr[23:16] == '0));
    // R9: a non-zero function of an internal device is never forwarded
    a_r9_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid[TGT_HOST] || tgt_req_valid[TGT_BRIDGE]) |-> (tgt_req_addr[10:8] == '0));
endmodule

// File: tb/tb_cfg_cycle_xlator.sv
module tb_cfg_cycle_xlator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        io_req_valid = 1'b0, io_req_ready, io_req_write = 1'b0;
    logic [13:0] io_req_dwaddr = '0;
    logic [3:0]  io_req_be = '0;
    logic [31:0] io_req_wdata = '0;
    logic        io_rsp_valid;
    logic [31:0] io_rsp_rdata;
    logic [7:0]  sec_bus = 8'd2, sub_bus = 8'd5;
    logic [3:0]  tgt_req_valid;
    logic        tgt_req_write, tgt_req_cfg, tgt_req_type1;
    logic [31:0] tgt_req_addr, tgt_req_wdata;
    logic [3:0]  tgt_req_be;
    logic [3:0]  tgt_cpl_valid = '0, tgt_cpl_absent = '0;
    logic [127:0] tgt_cpl_data = '0;

    cfg_cycle_xlator dut (.*);

    int checks = 0, failures = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // exp_tgt 4 = answered locally; cfg addr expected = car & 00FFFFFC
    task automatic access(string tag, logic wr, logic [13:0] dw, logic [3:0] be,
                          logic [31:0] wd, int exp_tgt, logic exp_cfg, logic exp_t1,
                          logic [31:0] exp_addr, logic [31:0] cdata, logic absent,
                          logic [31:0] exp_rd);
        @(negedge clk);
        chk(tag, "ready", {31'b0, io_req_ready}, 32'd1);
        io_req_valid = 1'b1; io_req_write = wr; io_req_dwaddr = dw;
        io_req_be = be; io_req_wdata = wd;
        @(negedge clk);
        io_req_valid = 1'b0;
        if (exp_tgt == 4) begin
            chk(tag, "no target req", {28'b0, tgt_req_valid}, 32'd0);
            chk(tag, "rsp valid", {31'b0, io_rsp_valid}, 32'd1);
            chk(tag, "rdata", io_rsp_rdata, exp_rd);
        end else begin
            chk(tag, "req valid", {28'b0, tgt_req_valid}, 32'd1 << exp_tgt);
            chk(tag, "req write", {31'b0, tgt_req_write}, {31'b0, wr});
            chk(tag, "req cfg", {31'b0, tgt_req_cfg}, {31'b0, exp_cfg});
            if (exp_cfg) chk(tag, "req type1", {31'b0, tgt_req_type1}, {31'b0, exp_t1});
            chk(tag, "req addr", tgt_req_addr, exp_addr);
            chk(tag, "req be", {28'b0, tgt_req_be}, {28'b0, be});
            if (wr) chk(tag, "req wdata", tgt_req_wdata, wd);
            chk(tag, "busy", {31'b0, io_req_ready}, 32'd0);   // R11
            tgt_cpl_valid[exp_tgt] = 1'b1;
            tgt_cpl_absent[exp_tgt] = absent;
            tgt_cpl_data[exp_tgt*32 +: 32] = cdata;
            @(negedge clk);
            tgt_cpl_valid = '0; tgt_cpl_absent = '0;
            chk(tag, "req pulse ended", {28'b0, tgt_req_valid}, 32'd0);   // R11
            chk(tag, "rsp valid", {31'b0, io_rsp_valid}, 32'd1);
            chk(tag, "rdata", io_rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(tag, "rsp pulse ended", {31'b0, io_rsp_valid}, 32'd0);   // R11
    endtask

    task automatic set_car(string tag, logic [31:0] v);
        access(tag, 1'b1, 14'h33E, 4'hF, v, 4, 1'b0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] car;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [2:0]  tgt;
        logic        type1;
        logic [31:0] cdata;
        logic        absent;
        logic [31:0] rdata;
    } vec_t;

    // sec_bus = 2, sub_bus = 5 during the table
    localparam vec_t VECS [11] = '{
        '{32'h8000_0010, 1'b0, 4'hF, 32'h0,         3'd0, 1'b0, 32'h1234_5678, 1'b0, 32'h1234_5678}, // R5 host
        '{32'h8000_080C, 1'b1, 4'h3, 32'hA5A5_0F0F, 3'd1, 1'b0, 32'h0,         1'b0, 32'h0},         // R5 R3 bridge
        '{32'h8000_0300, 1'b0, 4'hF, 32'h0,         3'd4, 1'b0, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R9 read
        '{32'h8000_0900, 1'b1, 4'hF, 32'hDEAD_BEEF, 3'd4, 1'b0, 32'h0,         1'b0, 32'h0},         // R9 write
        '{32'h8000_2800, 1'b0, 4'h6, 32'h0,         3'd2, 1'b0, 32'hCAFE_0001, 1'b0, 32'hCAFE_0001}, // R6
        '{32'h8002_0000, 1'b0, 4'hF, 32'h0,         3'd3, 1'b0, 32'h1111_2222, 1'b0, 32'h1111_2222}, // R7 type0
        '{32'h8005_1A00, 1'b1, 4'hC, 32'h0BAD_F00D, 3'd3, 1'b1, 32'h0,         1'b0, 32'h0},         // R7 type1
        '{32'h8004_0004, 1'b0, 4'hF, 32'h0,         3'd3, 1'b1, 32'h5555_6666, 1'b1, 32'hFFFF_FFFF}, // R10 gfx
        '{32'h8006_0000, 1'b0, 4'hF, 32'h0,         3'd2, 1'b1, 32'h7777_8888, 1'b0, 32'h7777_8888}, // R8 above
        '{32'h8001_0008, 1'b0, 4'h1, 32'h0,         3'd2, 1'b1, 32'h9999_AAAA, 1'b0, 32'h9999_AAAA}, // R8 below
        '{32'h8020_0000, 1'b0, 4'hF, 32'h0,         3'd2, 1'b1, 32'h0,         1'b1, 32'hFFFF_FFFF}  // R10 hub
    };

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R11", "reset ready", {31'b0, io_req_ready}, 32'd1);
        chk("R11", "reset rsp", {31'b0, io_rsp_valid}, 32'd0);
        chk("R11", "reset req", {28'b0, tgt_req_valid}, 32'd0);
        rst_n = 1'b1;
        access("R1", 1'b0, 14'h33E, 4'hF, 32'h0, 4, 1'b0, 1'b0, 0, 0, 1'b0, 32'h0);

        for (int i = 0; i < 11; i++) begin
            set_car("R1", VECS[i].car);
            access($sformatf("vec%0d", i), VECS[i].wr, 14'h33F, VECS[i].be, VECS[i].wdata,
                   int'(VECS[i].tgt), 1'b1, VECS[i].type1, VECS[i].car & 32'h00FF_FFFC,
                   VECS[i].cdata, VECS[i].absent, VECS[i].rdata);
        end

        // R1: reserved bits read back as zero
        set_car("R1", 32'hFFFF_FFFF);
        access("R1", 1'b0, 14'h33E, 4'h1, 32'h0, 4, 1'b0, 1'b0, 0, 0, 1'b0, 32'h80FF_FFFC);
        // R2: partial write goes out as I/O and leaves the register alone
        set_car("R2", 32'h8000_0010);
        access("R2", 1'b1, 14'h33E, 4'h1, 32'hFFFF_FFFF, 2, 1'b0, 1'b0, 32'h0000_0CF8, 0, 1'b0, 32'h0);
        access("R2", 1'b0, 14'h33E, 4'hF, 32'h0, 4, 1'b0, 1'b0, 0, 0, 1'b0, 32'h8000_0010);
        // R4: enable clear, data port becomes plain I/O
        set_car("R4", 32'h0000_0800);
        access("R4", 1'b0, 14'h33F, 4'hF, 32'h0, 2, 1'b0, 1'b0, 32'h0000_0CFC, 32'h0102_0304, 1'b0, 32'h0102_0304);
        access("R4", 1'b1, 14'h020, 4'h2, 32'h4455_6677, 2, 1'b0, 1'b0, 32'h0000_0080, 0, 1'b0, 32'h0);
        // R7: single-bus window, secondary equals subordinate
        sec_bus = 8'd3; sub_bus = 8'd3;
        set_car("R7", 32'h8003_0000);
        access("R7", 1'b0, 14'h33F, 4'hF, 32'h0, 3, 1'b1, 1'b0, 32'h0003_0000, 32'hABCD_0000, 1'b0, 32'hABCD_0000);
        set_car("R8", 32'h8004_0000);
        access("R8", 1'b0, 14'h33F, 4'hF, 32'h0, 2, 1'b1, 1'b1, 32'h0004_0000, 32'h0000_0042, 1'b0, 32'h0000_0042);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule